// File: doc/BRIEF.md
# I2C Slave Endpoint with General-Call Events

This block is the target side of a two-wire serial bus. It watches the clock and data lines all the time once enabled and recognises start and stop conditions. After each start it shifts in a 7-bit address with a read/write flag. The address is compared against a programmable own address and against the all-zero general-call address. On a match the block acknowledges. It then either shifts in data bytes from the bus master or shifts out bytes that software provides.

Software learns about each step from a one-cycle interrupt pulse plus a two-bit cause code that is valid in that same cycle. The events are: own address matched, general call matched, transmit byte wanted, and data byte received. The block only ever pulls SDA low and never drives it high. It never touches SCL, so there is no clock stretching. Transmit data must therefore be present before the SCL fall that ends the ninth clock of the current step. The block can sit beside a bus master in the same module.

Top module: `i2c_gc_slave`

## Requirements
- R1: While `enable` is low, and after reset, `sda_pull` is 0 and `irq` stays low; no address is acknowledged.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop in the middle of an address byte returns the block to idle, so a later byte with no new start is neither acknowledged nor reported.
- R3: An address byte (MSB first, 7 address bits then R/W, 1 = read) whose address equals `own_addr` is acknowledged for both R/W values. The block pulls SDA low through the ninth clock and pulses `irq` once with cause 0.
- R4: Address 7'b0000000 with R/W = 0 is a general call. It is acknowledged and reported with cause 1. Address 0 with R/W = 1 is neither acknowledged nor reported.
- R5: Any other address byte gets no acknowledge and no interrupt. SDA stays released until the next start.
- R6: In a write transfer, each data byte is shifted in MSB first and appears on `rx_byte`. `irq` pulses with cause 3 after the eighth SCL rise, and the byte is acknowledged on the ninth clock.
- R7: In a read transfer, `irq` pulses with cause 2 on the ninth clock of the address and of every byte the master acknowledges. `tx_data` is captured at the SCL fall that follows and is sent MSB first. SDA is released on the ninth clock of each transmitted byte.
- R8: If the master does not acknowledge a transmitted byte (SDA high on the ninth clock), the block releases SDA. It stays silent with no drive and no interrupt until the next start or stop.
- R9: A repeated start in the middle of a transfer restarts the address phase, and the new address is decoded as in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Module enable; low forces idle and releases SDA |
| own_addr | input | 7 | Programmable 7-bit slave address |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| tx_data | input | 8 | Byte to transmit, captured after a cause-2 interrupt |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| irq | output | 1 | One-cycle slave event pulse |
| irq_cause | output | 2 | 0 own address, 1 general call, 2 transmit request, 3 data received |
| rx_byte | output | 8 | Last received data byte |

## Verification
A change on `scl_in` or `sda_in` passes two synchroniser flops and one edge-detect register. `sda_pull`, `irq`, `irq_cause` and `rx_byte` therefore react at the third `clk` edge after the bus line moves. The bench holds every SCL phase for six `clk` cycles and samples SDA at the end of the high phase, well after the acknowledge or data bit has settled. Interrupts are captured by a monitor on the falling `clk` edge into a small log. Each check compares the log with the expected count and causes only after the whole byte, including its ninth clock, has been clocked. The address checks sweep all 128 addresses with both R/W values.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Event cause codes reported with each interrupt pulse
  typedef enum logic [1:0] {
    CAUSE_ADDR   = 2'd0,
    CAUSE_GCALL  = 2'd1,
    CAUSE_TXREQ  = 2'd2,
    CAUSE_RXDATA = 2'd3
  } cause_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  // data line moving while the clock line is held high
  assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_low,
  output logic              irq,
  output logic [1:0]        cause,
  output logic [DATA_W-1:0] rx_data
);

  localparam int               CNT_W   = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] GC_ADDR = '0;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKWAIT, S_ACKOUT, S_RX, S_TX, S_MACK, S_TXLOAD
  } st_t;

  st_t               state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              rw_q, rw_d;
  logic              drv_q, drv_d;
  logic              irq_q, irq_d;
  cause_t            cause_q, cause_d;

  logic [DATA_W-1:0] byte_in;
  logic              hit_own, hit_gc;

  assign byte_in = {sh_q[DATA_W-2:0], sda_s};
  assign hit_own = (byte_in[DATA_W-1 -: ADDR_W] == own_addr);
  assign hit_gc  = (byte_in[DATA_W-1 -: ADDR_W] == GC_ADDR) && !sda_s;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    rw_d    = rw_q;
    drv_d   = drv_q;
    irq_d   = 1'b0;
    cause_d = cause_q;

    if (!enable) begin
      state_d = S_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else if (start_det) begin
      state_d = S_ADDR;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else if (stop_det) begin
      state_d = S_IDLE;
      drv_d   = 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR: if (scl_rise) begin
          sh_d  = byte_in;
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == LAST) begin
            cnt_d = '0;
            if (hit_own) begin
              irq_d = 1'b1; cause_d = CAUSE_ADDR;  rw_d = sda_s; state_d = S_ACKWAIT;
            end else if (hit_gc) begin
              irq_d = 1'b1; cause_d = CAUSE_GCALL; rw_d = 1'b0;  state_d = S_ACKWAIT;
            end else begin
              state_d = S_IDLE;
            end
          end
        end
        S_ACKWAIT: if (scl_fall) begin
          drv_d   = 1'b1;
          state_d = S_ACKOUT;
        end
        S_ACKOUT: begin
          if (scl_rise && rw_q) begin
            irq_d = 1'b1; cause_d = CAUSE_TXREQ;
          end
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d = tx_data; drv_d = !tx_data[DATA_W-1]; state_d = S_TX;
            end else begin
              drv_d = 1'b0; state_d = S_RX;
            end
          end
        end
        S_RX: if (scl_rise) begin
          sh_d = byte_in;
          if (cnt_q == LAST) begin
            cnt_d = '0; rx_d = byte_in;
            irq_d = 1'b1; cause_d = CAUSE_RXDATA; state_d = S_ACKWAIT;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        S_TX: if (scl_fall) begin
          if (cnt_q == LAST) begin
            cnt_d = '0; drv_d = 1'b0; state_d = S_MACK;
          end else begin
            sh_d  = {sh_q[DATA_W-2:0], 1'b0};
            drv_d = !sh_q[DATA_W-2];
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        S_MACK: if (scl_rise) begin
          if (!sda_s) begin
            irq_d = 1'b1; cause_d = CAUSE_TXREQ; state_d = S_TXLOAD;
          end else begin
            state_d = S_IDLE;
          end
        end
        S_TXLOAD: if (scl_fall) begin
          cnt_d = '0; sh_d = tx_data; drv_d = !tx_data[DATA_W-1]; state_d = S_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      rw_q    <= 1'b0;
      drv_q   <= 1'b0;
      irq_q   <= 1'b0;
      cause_q <= CAUSE_ADDR;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      rw_q    <= rw_d;
      drv_q   <= drv_d;
      irq_q   <= irq_d;
      cause_q <= cause_d;
    end
  end

  assign sda_low = drv_q;
  assign irq     = irq_q;
  assign cause   = cause_q;
  assign rx_data = rx_q;

  // R1: disabled block is quiet from the next cycle on
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drv_q && !irq_q));
  // R6: every event is a single-cycle pulse
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R7: while sending, the drive always mirrors the current MSB
  a_r7_tx_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TX) |-> (drv_q == !sh_q[DATA_W-1]));
  // R4: a general call is only ever a write
  a_r4_gc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && cause_q == CAUSE_GCALL) |-> !rw_q);
  // R5: nothing is driven while idle
  a_r5_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !drv_q);
  // R8: a missing master acknowledge releases the line and goes idle
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !start_det && !stop_det && state_q == S_MACK && scl_rise && sda_s)
      |=> (!drv_q && state_q == S_IDLE && !irq_q));

endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_pull,
  output logic              irq,
  output logic [1:0]        irq_cause,
  output logic [DATA_W-1:0] rx_byte
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [1:0] bus_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({scl_in, sda_in}), .q(bus_s)
  );

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_sn), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_sn), .enable(enable), .own_addr(own_addr),
    .sda_s(bus_s[0]), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tx_data(tx_data),
    .sda_low(sda_pull), .irq(irq), .cause(irq_cause), .rx_data(rx_byte)
  );

endmodule

// File: tb/sim_i2c_gc_slave.sv
`timescale 1ns/1ps
module sim_i2c_gc_slave;
  localparam int         H   = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, enable, scl_m, sda_m;
  logic [6:0] own;
  logic [7:0] txd;
  wire        sda_pull, irq;
  wire [1:0]  cause;
  wire [7:0]  rxb;
  wire        sda_line = sda_m & ~sda_pull;

  i2c_gc_slave u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(own),
    .scl_in(scl_m), .sda_in(sda_line), .tx_data(txd),
    .sda_pull(sda_pull), .irq(irq), .irq_cause(cause), .rx_byte(rxb)
  );

  int checks = 0, errors = 0;
  int ev_cnt = 0, txreq_cnt = 0;
  logic [1:0] cause_log [16];
  logic [7:0] rx_log    [16];

  function automatic logic [7:0] txf(input int k);
    return 8'((k * 37 + 91) % 256);
  endfunction

  assign txd = txf(txreq_cnt);

  always @(negedge clk) begin
    if (irq) begin
      cause_log[ev_cnt % 16] <= cause;
      rx_log[ev_cnt % 16]    <= rxb;
      ev_cnt <= ev_cnt + 1;
      if (cause == 2'd2) txreq_cnt <= txreq_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hp(); scl_m = 1'b1; hp(); s = sda_line; scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_low);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack_low = !s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(!m_ack, s);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       ack, s;
    logic [7:0] v, expb;
    int         base;
    rst_n = 1'b0; enable = 1'b1; own = OWN; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk(sda_pull == 1'b0, "R1 reset sda_pull", sda_pull, 0);
    chk(irq == 1'b0 && ev_cnt == 0, "R1 reset irq", ev_cnt, 0);

    // R3 R4 R5: full write-address sweep
    for (int a = 0; a < 128; a++) begin
      bit exp_ack;
      exp_ack = (7'(a) == OWN) || (a == 0);
      base = ev_cnt;
      start_c();
      send_byte({7'(a), 1'b0}, ack);
      if (7'(a) == OWN)  chk(ack == 1'b1, "R3 own write ack", ack, 1);
      else if (a == 0)   chk(ack == 1'b1, "R4 gcall write ack", ack, 1);
      else               chk(ack == 1'b0, "R5 foreign write no ack", ack, 0);
      chk(ev_cnt - base == int'(exp_ack), "R5 address irq count", ev_cnt - base, int'(exp_ack));
      if (exp_ack)
        chk(cause_log[base % 16] == (a == 0 ? 2'd1 : 2'd0), "R4 address cause",
            cause_log[base % 16], (a == 0 ? 1 : 0));
      stop_c();
    end

    // R3 R4 R7: full read-address sweep
    for (int a = 0; a < 128; a++) begin
      bit exp_ack;
      exp_ack = (7'(a) == OWN);
      base = ev_cnt;
      start_c();
      send_byte({7'(a), 1'b1}, ack);
      if (a == 0) chk(ack == 1'b0, "R4 gcall read not acked", ack, 0);
      else        chk(ack == exp_ack, "R3 read address ack", ack, int'(exp_ack));
      chk(ev_cnt - base == (exp_ack ? 2 : 0), "R7 read address irq count",
          ev_cnt - base, (exp_ack ? 2 : 0));
      if (exp_ack) begin
        chk(cause_log[base % 16] == 2'd0 && cause_log[(base + 1) % 16] == 2'd2,
            "R7 address then txreq cause", cause_log[(base + 1) % 16], 2);
        expb = txf(txreq_cnt);
        recv_byte(1'b0, v);
        chk(v == expb, "R7 first read byte", v, expb);
      end
      stop_c();
    end

    // R6: write data bytes
    start_c();
    send_byte({OWN, 1'b0}, ack);
    chk(ack, "R6 address ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h3C;
      base = ev_cnt;
      send_byte(d, ack);
      chk(ack, "R6 data ack", ack, 1);
      chk(ev_cnt - base == 1, "R6 data irq count", ev_cnt - base, 1);
      chk(cause_log[base % 16] == 2'd3, "R6 data cause", cause_log[base % 16], 3);
      chk(rx_log[base % 16] == d, "R6 data value", rx_log[base % 16], d);
      chk(rxb == d, "R6 rx_byte held", rxb, d);
    end

    // R9: repeated start to a read, R7 multi-byte, R8 nack
    base = ev_cnt;
    start_c();
    send_byte({OWN, 1'b1}, ack);
    chk(ack, "R9 repeated start address ack", ack, 1);
    chk(ev_cnt - base == 2, "R9 repeated start irq count", ev_cnt - base, 2);
    expb = txf(txreq_cnt);
    base = ev_cnt;
    recv_byte(1'b1, v);
    chk(v == expb, "R7 read byte acked", v, expb);
    chk(ev_cnt - base == 1 && cause_log[base % 16] == 2'd2, "R7 txreq after master ack",
        ev_cnt - base, 1);
    expb = txf(txreq_cnt);
    base = ev_cnt;
    recv_byte(1'b0, v);
    chk(v == expb, "R7 read byte nacked", v, expb);
    chk(ev_cnt - base == 0, "R8 no irq after nack", ev_cnt - base, 0);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk(s == 1'b1, "R8 line released after nack", s, 1);
    end
    chk(ev_cnt - base == 0, "R8 silent until start", ev_cnt - base, 0);
    stop_c();

    // R2: stop in the middle of an address byte
    start_c();
    for (int i = 6; i >= 3; i--) clk_bit(OWN[i], s);
    stop_c();
    base = ev_cnt;
    scl_m = 1'b0; repeat (2) @(negedge clk);
    send_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0, "R2 no ack after stop", ack, 0);
    chk(ev_cnt - base == 0, "R2 no irq after stop", ev_cnt - base, 0);
    stop_c();
    start_c();
    send_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b1, "R2 ack after fresh start", ack, 1);
    stop_c();

    // R1: disabled block ignores its address
    enable = 1'b0;
    base = ev_cnt;
    start_c();
    send_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0, "R1 disabled no ack", ack, 0);
    chk(ev_cnt - base == 0, "R1 disabled no irq", ev_cnt - base, 0);
    chk(sda_pull == 1'b0, "R1 disabled no drive", sda_pull, 0);
    stop_c();
    enable = 1'b1;
    start_c();
    send_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b1, "R1 re-enabled ack", ack, 1);
    stop_c();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule